// File: doc/BRIEF.md
# UART interrupt mask and status unit

This block gathers the event pulses of one UART channel into a sticky raw interrupt status word. It gates that word with a mask and drives a single registered interrupt line. Software cannot write the mask directly. A write-only enable register sets mask bits, a write-only disable register clears them, and the mask itself reads back but ignores writes. Raw status bits latch whether or not they are enabled, and software clears them by writing ones.

A second, live channel status word reports the channel's current FIFO levels and state-machine activity without latching. All five registers sit behind a simple single-cycle request port whose read data arrives one cycle after the request.

Top module: `uart_irq_unit`

## Requirements
- R1: While rst_ni is low and after its release, the mask, the raw status, irq_o and rdata_o are all zero.
- R2: A write to address 0 (enable) sets every mask bit whose wdata_i bit is 1 and leaves the other mask bits unchanged. The mask is 13 bits, and a mask bit of 1 enables the matching status bit.
- R3: A write to address 1 (disable) clears every mask bit whose wdata_i bit is 1 and leaves the other mask bits unchanged.
- R4: Address 2 reads back the mask in bits 12:0, and writes to it are ignored. Reads of addresses 0 and 1 return zero.
- R5: A 1 on evt_i[k] sets raw status bit k on the next clock edge whatever the mask holds. Address 3 reads the raw status. The bit layout, from bit 0 upward, is: rx trigger, rx empty, rx full, tx empty, tx full, rx overflow, framing error, parity error, rx timeout, modem status change, tx trigger, tx nearly full, tx overflow.
- R6: A write to address 3 clears each raw status bit whose wdata_i bit is 1. If an event pulse and such a clear hit the same bit in one cycle, the bit ends up set.
- R7: irq_o is registered. After each clock edge it equals the OR over all bits of (raw status AND mask) as they stood before that edge.
- R8: Address 4 returns the live channel status and ignores writes. Bits 4:0 carry lvl_i[4:0] (rx trigger, rx empty, rx full, tx empty, tx full). Bit 10 is rx_busy_i, bit 11 is tx_busy_i, bit 12 is flow_dly_i, bit 13 is lvl_i[5] (tx trigger) and bit 14 is lvl_i[6] (tx nearly full). All other bits read zero.
- R9: rdata_o is registered. After an edge with a read request it holds the addressed value sampled at that edge, and otherwise it is zero. Addresses 5 to 7 and bits above those defined read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 13 | Event pulses, one per raw status bit |
| lvl_i | input | 7 | Live FIFO levels: rx trig, rx empty, rx full, tx empty, tx full, tx trig, tx nearly full |
| rx_busy_i | input | 1 | Receiver is shifting in a character |
| tx_busy_i | input | 1 | Transmitter is shifting out a character |
| flow_dly_i | input | 1 | RX FIFO level is at or above the flow delay level |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after the request |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that evt_i is sampled only at clock edges, and that a request and its address are stable and known whenever req_i is high. They also assume that only one register access occurs per cycle, so enable and disable can never act in the same cycle. The stimulus changes every input only at the falling edge and drives a single access per cycle. Event pulses are sparse random 13-bit vectors, some of them placed in the same cycle as status clears. Random request traffic also reaches the unmapped addresses 5 to 7.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int N_EVT  = 13;
  localparam int CHAN_W = 15;
  localparam int N_LVL  = 7;

  typedef enum logic [2:0] {
    A_IEN  = 3'd0,
    A_IDIS = 3'd1,
    A_MASK = 3'd2,
    A_STAT = 3'd3,
    A_CHAN = 3'd4
  } reg_addr_e;

  // channel status bit positions beyond the shared low five
  localparam int CH_RX_BUSY = 10;
  localparam int CH_TX_BUSY = 11;
  localparam int CH_FDLY    = 12;
  localparam int CH_TX_TRIG = 13;
  localparam int CH_TX_NFUL = 14;
  localparam int N_SHARED   = 5;
endpackage

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int W = 13
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else         mask_q <= (mask_q | set_i) & ~clr_i;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/irq_sticky_reg.sv
module irq_sticky_reg #(
  parameter int W = 13
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o
);
  for (genvar k = 0; k < W; k++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       bit_q <= 1'b0;
      else if (evt_i[k]) bit_q <= 1'b1;  // event beats clear
      else if (clr_i[k]) bit_q <= 1'b0;
    end
    assign stat_o[k] = bit_q;
  end
endmodule

// File: rtl/chan_status_pack.sv
module chan_status_pack
  import uart_irq_pkg::*;
(
  input  logic [N_LVL-1:0]  lvl_i,
  input  logic              rx_busy_i,
  input  logic              tx_busy_i,
  input  logic              flow_dly_i,
  output logic [CHAN_W-1:0] chan_o
);
  always_comb begin
    chan_o                = '0;
    chan_o[N_SHARED-1:0]  = lvl_i[N_SHARED-1:0];
    chan_o[CH_RX_BUSY]    = rx_busy_i;
    chan_o[CH_TX_BUSY]    = tx_busy_i;
    chan_o[CH_FDLY]       = flow_dly_i;
    chan_o[CH_TX_TRIG]    = lvl_i[5];
    chan_o[CH_TX_NFUL]    = lvl_i[6];
  end
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
  import uart_irq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_EVT-1:0]  wbits_i,
  input  logic [N_EVT-1:0]  mask_i,
  input  logic [N_EVT-1:0]  stat_i,
  input  logic [CHAN_W-1:0] chan_i,
  output logic [N_EVT-1:0]  set_o,
  output logic [N_EVT-1:0]  dis_o,
  output logic [N_EVT-1:0]  clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic wr, rd;
  logic [DATA_W-1:0] rd_val, rdata_q;

  assign wr = req_i &  we_i;
  assign rd = req_i & ~we_i;

  assign set_o = (wr && addr_i == ADDR_W'(A_IEN))  ? wbits_i : '0;
  assign dis_o = (wr && addr_i == ADDR_W'(A_IDIS)) ? wbits_i : '0;
  assign clr_o = (wr && addr_i == ADDR_W'(A_STAT)) ? wbits_i : '0;

  always_comb begin
    rd_val = '0;
    if (addr_i == ADDR_W'(A_MASK))      rd_val[N_EVT-1:0]  = mask_i;
    else if (addr_i == ADDR_W'(A_STAT)) rd_val[N_EVT-1:0]  = stat_i;
    else if (addr_i == ADDR_W'(A_CHAN)) rd_val[CHAN_W-1:0] = chan_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rd ? rd_val : '0;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/uart_irq_unit.sv
module uart_irq_unit
  import uart_irq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_EVT-1:0]  evt_i,
  input  logic [N_LVL-1:0]  lvl_i,
  input  logic              rx_busy_i,
  input  logic              tx_busy_i,
  input  logic              flow_dly_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [N_EVT-1:0]  mask_q, stat_q, set_v, dis_v, clr_v;
  logic [CHAN_W-1:0] chan_w;
  logic              irq_q;
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:N_EVT];

  irq_reg_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_port (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wbits_i (wdata_i[N_EVT-1:0]),
    .mask_i  (mask_q),
    .stat_i  (stat_q),
    .chan_i  (chan_w),
    .set_o   (set_v),
    .dis_o   (dis_v),
    .clr_o   (clr_v),
    .rdata_o (rdata_o)
  );

  irq_mask_reg #(.W(N_EVT)) u_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_v),
    .clr_i  (dis_v),
    .mask_o (mask_q)
  );

  irq_sticky_reg #(.W(N_EVT)) u_stat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt_i),
    .clr_i  (clr_v),
    .stat_o (stat_q)
  );

  chan_status_pack u_chan (
    .lvl_i      (lvl_i),
    .rx_busy_i  (rx_busy_i),
    .tx_busy_i  (tx_busy_i),
    .flow_dly_i (flow_dly_i),
    .chan_o     (chan_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(stat_q & mask_q);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/uart_irq_checker.sv
module uart_irq_checker
  import uart_irq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_EVT-1:0]  evt_i,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              irq_o,
  input logic [N_EVT-1:0]  mask_q,
  input logic [N_EVT-1:0]  stat_q
);
  logic wr_en, wr_dis, wr_stat;
  assign wr_en   = req_i && we_i && addr_i == ADDR_W'(A_IEN);
  assign wr_dis  = req_i && we_i && addr_i == ADDR_W'(A_IDIS);
  assign wr_stat = req_i && we_i && addr_i == ADDR_W'(A_STAT);

  AST_EN_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |=> ((mask_q & $past(wdata_i[N_EVT-1:0])) == $past(wdata_i[N_EVT-1:0]))); // R2
  AST_DIS_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_dis |=> ((mask_q & $past(wdata_i[N_EVT-1:0])) == '0)); // R3
  AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en || wr_dis) |=> $stable(mask_q)); // R4
  AST_EVT_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((stat_q & $past(evt_i)) == $past(evt_i))); // R5
  AST_NO_SPONT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(evt_i)) == '0)); // R5
  AST_CLR_ONLY_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_stat |=> ((~stat_q & $past(stat_q)) == '0)); // R6
  AST_IRQ_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == |($past(stat_q) & $past(mask_q)))); // R7
  AST_RDATA_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> (rdata_o == '0)); // R9
  AST_RDATA_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DATA_W-1:CHAN_W] == '0); // R9
endmodule

bind uart_irq_unit uart_irq_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .evt_i   (evt_i),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o),
  .mask_q  (mask_q),
  .stat_q  (stat_q)
);

// File: tb/uart_irq_unit_bench.sv
module uart_irq_unit_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [12:0] evt_i = '0;
  logic [6:0]  lvl_i = '0;
  logic        rx_busy_i = 1'b0, tx_busy_i = 1'b0, flow_dly_i = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int n_chk = 0, n_fail = 0;
  logic [12:0] m_mask = '0, m_stat = '0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  uart_irq_unit u_uart_irq_unit (.*);

  function automatic logic [31:0] chan_word(logic [6:0] l, logic rb, logic tb, logic fd);
    logic [31:0] v = '0;
    v[4:0] = l[4:0];
    v[10] = rb; v[11] = tb; v[12] = fd; v[13] = l[5]; v[14] = l[6];
    return v;
  endfunction

  function automatic logic [31:0] exp_read(logic [2:0] a, logic [31:0] ch);
    case (a)
      3'd2:    return {19'd0, m_mask};
      3'd3:    return {19'd0, m_stat};
      3'd4:    return ch;
      default: return '0;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, model update, check after following negedge
  task automatic step(logic [12:0] ev, logic rq, logic w, logic [2:0] a,
                      logic [31:0] wd, logic [6:0] l, logic rb, logic tb,
                      logic fd, string tag);
    logic [31:0] e_rd;
    logic        e_irq;
    logic [12:0] clr;
    evt_i = ev; req_i = rq; we_i = w; addr_i = a; wdata_i = wd;
    lvl_i = l; rx_busy_i = rb; tx_busy_i = tb; flow_dly_i = fd;
    e_rd  = (rq && !w) ? exp_read(a, chan_word(l, rb, tb, fd)) : '0;
    e_irq = |(m_stat & m_mask);
    clr   = '0;
    if (rq && w) begin
      if (a == 3'd0) m_mask = m_mask | wd[12:0];
      if (a == 3'd1) m_mask = m_mask & ~wd[12:0];
      if (a == 3'd3) clr = wd[12:0];
    end
    m_stat = (m_stat & ~clr) | ev;
    @(posedge clk_i);
    @(negedge clk_i);
    check({tag, " rdata"}, rdata_o, e_rd);
    check("R7 irq", {31'd0, irq_o}, {31'd0, e_irq});
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d, string tag);
    step('0, 1, 1, a, d, '0, 0, 0, 0, tag);
  endtask

  task automatic rd(logic [2:0] a, string tag);
    step('0, 1, 0, a, '0, '0, 0, 0, 0, tag);
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk_i);
      if (done) break;
    end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk_i); @(negedge clk_i);
    check("R1 irq in reset", {31'd0, irq_o}, '0);
    check("R1 rdata in reset", rdata_o, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    rd(3'd2, "R1 mask after reset");
    rd(3'd3, "R1 status after reset");

    // R2 / R3 enable and disable
    wr(3'd0, 32'h0000_0A05, "R2 write enable");
    wr(3'd0, 32'h0000_0100, "R2 second enable");
    rd(3'd2, "R2 mask readback");
    wr(3'd1, 32'h0000_0004, "R3 disable");
    rd(3'd2, "R3 mask readback");
    // R4 mask write ignored, en/dis read zero
    wr(3'd2, 32'h0000_1FFF, "R4 mask write");
    rd(3'd2, "R4 mask unchanged");
    rd(3'd0, "R4 enable reads zero");
    rd(3'd1, "R4 disable reads zero");

    // R5 latch on unmasked bit, R7 stays low
    step(13'h1000, 0, 0, 0, '0, '0, 0, 0, 0, "R5 event");
    rd(3'd3, "R5 status latched unmasked");
    step(13'h0001, 0, 0, 0, '0, '0, 0, 0, 0, "R7 enabled event");
    rd(3'd3, "R5 status two bits");
    // R6 same-cycle event and clear
    step(13'h0001, 1, 1, 3'd3, 32'h0000_1001, '0, 0, 0, 0, "R6 event+clear");
    rd(3'd3, "R6 event wins");
    wr(3'd3, 32'h0000_0001, "R6 clear");
    rd(3'd3, "R6 cleared");

    // R8 channel status live, writes ignored
    step('0, 1, 0, 3'd4, '0, 7'h55, 1, 0, 1, "R8 chan read a");
    step('0, 1, 0, 3'd4, '0, 7'h2A, 0, 1, 0, "R8 chan read b");
    step('0, 1, 1, 3'd4, '1, 7'h00, 0, 0, 0, "R8 chan write");
    rd(3'd4, "R8 chan after write");
    // R9 unmapped
    rd(3'd5, "R9 addr5"); rd(3'd6, "R9 addr6"); rd(3'd7, "R9 addr7");

    for (int i = 0; i < 3000; i++) begin
      logic [12:0] ev;
      logic [31:0] wd;
      ev = ($urandom % 5 == 0) ? 13'($urandom) & 13'($urandom) : '0;
      wd = $urandom;
      step(ev, ($urandom % 3) != 0, $urandom % 2, 3'($urandom), wd,
           7'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), "R9 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule